// File: doc/BRIEF.md
# Sequential Result Readout Port

This block puts four stored conversion results behind one host location. The host selects the block with an active-low chip select and strobes an active-low read line. Each completed read cycle moves an internal pointer on to the next result, so four back-to-back reads return channel 1, 2, 3 and 4 in that order. The host has no way to pick a register by address.

The conversion controller supplies the results as one packed vector, a convert-start level, a busy level and a one-cycle completion strobe. A rising edge on convert-start puts the pointer back to channel 1. The completion strobe pulls the active-low interrupt down. The falling edge of read in the first read pulls it back high. After the fourth read the pointer stays on channel 4 until the next convert-start. A read issued while the controller is busy returns data but does not move the pointer, and it raises a one-cycle debug flag.

All host inputs are taken to be already synchronous to `clk`. The data bus is shown as a value plus a drive-enable, ready to feed a pad's three-state buffer.

Top module: `seq_readout`

## Requirements
- R1: After reset, `irq_n` is 1, `bus_oe` is 0, and the first read returns channel 1 (bits [11:0] of `results`).
- R2: `bus_oe` is 1 exactly while `cs_n` and `rd_n` are both 0.
- R3: Successive completed reads (read rises while `cs_n` is 0 and `busy` is 0) return channel 1, 2, 3 and 4 in order. Channel k occupies `results[12*k-1 : 12*(k-1)]`.
- R4: After the fourth read the pointer saturates. Every further read returns channel 4 until the next convert-start edge.
- R5: A rising edge on `conv_start` returns the pointer to channel 1 from any position.
- R6: One cycle after `conv_done` is sampled high, `irq_n` is 0.
- R7: The first cycle after `rd_n` is sampled falling with `cs_n` 0 and `busy` 0, `irq_n` is 1.
- R8: Read strobes while `cs_n` is 1 do not move the pointer.
- R9: A read issued while `busy` is 1 does not move the pointer. In the cycle after its falling edge, `busy_rd` is 1 for exactly one cycle.
- R10: `bus_data` is 0 whenever `bus_oe` is 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| cs_n | input | 1 | Active-low chip select |
| rd_n | input | 1 | Active-low read strobe |
| conv_start | input | 1 | Convert-start level; its rising edge resets the pointer |
| conv_done | input | 1 | One-cycle completion strobe from the controller |
| busy | input | 1 | Controller conversion in progress |
| results | input | 48 | Four packed 12-bit results, channel 1 in the low bits |
| bus_data | output | 12 | Data toward the host bus |
| bus_oe | output | 1 | Drive enable for the bus buffer |
| irq_n | output | 1 | Active-low completion interrupt |
| busy_rd | output | 1 | One-cycle flag for a read issued during busy |

## Verification
The main sweep loads several result patterns: all zeros, all ones, alternating bits and arithmetic ramps. Each pattern is followed by six reads. Distinct values per channel show that the order is right. The fifth and sixth reads tell saturation apart from wrap-around. Further runs cover a convert-start issued partway through a read sequence, strobes with chip select high, and a read during busy. Each of these must leave the pointer where it was, and this is seen in the value returned by the next normal read.

// File: rtl/seq_readout.sv
module seq_readout #(
  parameter int W   = 12,
  parameter int NCH = 4
) (
  input  logic           clk,
  input  logic           rst_n,
  input  logic           cs_n,
  input  logic           rd_n,
  input  logic           conv_start,
  input  logic           conv_done,
  input  logic           busy,
  input  logic [NCH*W-1:0] results,
  output logic [W-1:0]   bus_data,
  output logic           bus_oe,
  output logic           irq_n,
  output logic           busy_rd
);
  localparam int PW = (NCH > 1) ? $clog2(NCH) : 1;
  localparam logic [PW-1:0] LAST = PW'(NCH - 1);

  logic [PW-1:0] ptr;
  logic          rd_q, start_q;

  wire start_rise = conv_start & ~start_q;
  wire rd_fall    = rd_q & ~rd_n & ~cs_n;
  wire rd_rise    = ~rd_q & rd_n & ~cs_n;

  assign bus_oe   = ~cs_n & ~rd_n;
  assign bus_data = bus_oe ? results[ptr*W +: W] : '0;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      rd_q    <= 1'b1;
      start_q <= 1'b0;
      ptr     <= '0;
      irq_n   <= 1'b1;
      busy_rd <= 1'b0;
    end else begin
      rd_q    <= rd_n;
      start_q <= conv_start;
      busy_rd <= rd_fall & busy;
      if (start_rise)
        ptr <= '0;
      else if (rd_rise && !busy && ptr != LAST)
        ptr <= ptr + 1'b1;
      if (conv_done)
        irq_n <= 1'b0;
      else if (rd_fall && !busy)
        irq_n <= 1'b1;
    end
  end

  p_ptr_home_r5: assert property (@(posedge clk) disable iff (!rst_n)
    start_rise |=> ptr == '0);
  p_irq_low_r6: assert property (@(posedge clk) disable iff (!rst_n)
    conv_done |=> !irq_n);
  p_irq_clear_r7: assert property (@(posedge clk) disable iff (!rst_n)
    (rd_fall && !busy && !conv_done) |=> irq_n);
  p_saturate_r4: assert property (@(posedge clk) disable iff (!rst_n)
    (ptr == LAST && !start_rise) |=> ptr == LAST);
  p_busy_hold_r9: assert property (@(posedge clk) disable iff (!rst_n)
    (busy && !start_rise) |=> $stable(ptr));
  p_unselected_r8: assert property (@(posedge clk) disable iff (!rst_n)
    (cs_n && !start_rise) |=> $stable(ptr));
endmodule

// File: tb/seq_readout_bench.sv
module seq_readout_bench;
  localparam int W = 12, NCH = 4;
  logic clk = 0, rst_n = 0, cs_n = 1, rd_n = 1, conv_start = 0, conv_done = 0, busy = 0;
  logic [NCH*W-1:0] results = '0;
  logic [W-1:0] bus_data;
  logic bus_oe, irq_n, busy_rd;
  int n_chk = 0, n_bad = 0;
  logic [W-1:0] rv;
  logic rf;

  always #2 clk = ~clk;

  seq_readout #(.W(W), .NCH(NCH)) u_seq_readout (
    .clk, .rst_n, .cs_n, .rd_n, .conv_start, .conv_done, .busy, .results,
    .bus_data, .bus_oe, .irq_n, .busy_rd);

  task automatic chk(input string tag, input int act, input int exp);
    n_chk++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s: actual %0d expected %0d", tag, act, exp);
    end
  endtask

  function automatic logic [W-1:0] chan(input int k);
    return results[k*W +: W];
  endfunction

  task automatic do_read(output logic [W-1:0] d, output logic flag);
    @(negedge clk) cs_n = 0;
    @(negedge clk) begin chk("R2 oe with rd high", bus_oe, 0); chk("R10 idle data", bus_data, 0); rd_n = 0; end
    @(negedge clk) begin
      chk("R2 oe during read", bus_oe, 1);
      d = bus_data; flag = busy_rd;
    end
    @(negedge clk) begin chk("R9 flag one cycle", busy_rd, 0); rd_n = 1; end
    @(negedge clk) cs_n = 1;
    @(negedge clk);
  endtask

  task automatic convert();
    @(negedge clk) begin conv_start = 1; busy = 1; end
    repeat (3) @(negedge clk);
    conv_start = 0; busy = 0; conv_done = 1;
    @(negedge clk) begin conv_done = 0; chk("R6 irq low after done", irq_n, 0); end
  endtask

  initial begin : watchdog
    repeat (100000) @(posedge clk);
    n_chk++; n_bad++;
    $display("FAIL watchdog: actual timeout expected finish");
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
    $finish;
  end

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1;
    @(negedge clk);
    chk("R1 irq after reset", irq_n, 1);
    chk("R1 oe after reset", bus_oe, 0);
    results = {12'd44, 12'd33, 12'd22, 12'd11};
    do_read(rv, rf);
    chk("R1 first read ch1", rv, 11);

    for (int p = 0; p < 8; p++) begin
      for (int c = 0; c < NCH; c++)
        results[c*W +: W] = (p == 0) ? 12'h000 : (p == 1) ? 12'hFFF :
                            (p == 2) ? ((c % 2) ? 12'h555 : 12'hAAA) :
                            12'((p * 1234 + c * 517 + 7) & 12'hFFF);
      convert();
      for (int r = 0; r < 6; r++) begin
        do_read(rv, rf);
        if (r == 0) chk("R7 irq cleared by first read", irq_n, 1);
        if (r < NCH) chk("R3 ordered read", rv, chan(r));
        else         chk("R4 saturated at ch4", rv, chan(NCH - 1));
      end
    end

    results = {12'd400, 12'd300, 12'd200, 12'd100};
    convert();
    do_read(rv, rf); do_read(rv, rf);
    chk("R3 second read ch2", rv, 200);
    convert();
    do_read(rv, rf);
    chk("R5 restart returns ch1", rv, 100);

    repeat (3) begin
      @(negedge clk) rd_n = 0;
      @(negedge clk) begin chk("R2 oe with cs high", bus_oe, 0); chk("R10 zero data", bus_data, 0); end
      @(negedge clk) rd_n = 1;
      @(negedge clk);
    end
    do_read(rv, rf);
    chk("R8 unselected strobes ignored", rv, 200);

    @(negedge clk) begin conv_start = 1; busy = 1; end
    @(negedge clk) conv_start = 0;
    do_read(rv, rf);
    chk("R9 busy_rd flagged", rf, 1);
    chk("R9 busy read data ch1", rv, 100);
    @(negedge clk) begin busy = 0; conv_done = 1; end
    @(negedge clk) conv_done = 0;
    do_read(rv, rf);
    chk("R9 pointer held across busy read", rv, 100);
    chk("R9 no flag when idle", rf, 0);

    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
    $finish;
  end
endmodule